// File: doc/BRIEF.md
# Time-Slot Bit Overwrite Inserter

This block sits in the transmit path of a T1 framed serial stream and replaces chosen bit positions with bits taken from an external NRZ data pin. A position input reports, every clock, which bit of the 193-bit frame is being presented: slot 0 is the framing bit, and slots 1 to 24 are payload time slots sent MSB first as bit index 0 (first sent) through 7. The position input also carries the parity of the current frame.

Configuration selects one time slot code, an 8-bit mask of positions within that slot, a frame parity filter, an enable and a pin-mode select. When a selected position comes up, the block raises a one-cycle strobe on `ext_clk`. The external source answers with one bit on `ext_data`. That bit is sampled at the end of the strobe cycle and sent out in place of the normal bit. The whole configuration is taken only on the framing-bit cycle, so each frame is processed under a single setting.

Top module: `tsi_inserter`

## Requirements
- R1: While and right after reset, `ext_clk` and `tx_out` are 0 and the active configuration is disabled until the next framing-bit cycle.
- R2: Slot codes 1 to 24 select that payload slot. Mask bit k (bit 0 = first sent bit, bit 7 = last) selects `bit_num == k`, and any combination of mask bits may be set.
- R3: Every bit that is not replaced appears on `tx_out` two clock cycles after it is presented on `tx_in`.
- R4: The parity code filters frames as follows: 0 selects all frames, 1 selects odd frames only (`frame_odd = 1`), 2 selects even frames only, and 3 selects all frames.
- R5: Slot code 31 selects the framing bit (`slot_num == 0`). For this code only mask bit 0 counts, and mask bits 1 to 7 have no effect.
- R6: Slot code 0 and codes 25 to 30 disable the block: no strobe is raised and the data passes through unchanged.
- R7: With the enable clear, no strobe is raised and no bit is replaced.
- R8: With the pin-mode select clear, `ext_clk` stays low and no bit is replaced.
- R9: Configuration inputs are taken only in the cycle where `slot_num == 0`, and they govern that whole frame. Changes made at other times have no effect until the next framing bit.
- R10: A selected position presented in cycle t raises `ext_clk` for exactly cycle t+1. The value on `ext_data` at the end of that cycle appears on `tx_out` in cycle t+2, so one bit is taken per strobe.
- R11: `ext_data` is ignored in every cycle where `ext_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_num | input | 5 | Current slot: 0 = framing bit, 1..24 payload |
| bit_num | input | 3 | Bit within the slot, 0 = first sent |
| frame_odd | input | 1 | 1 while the current frame is odd |
| tx_in | input | 1 | Normal transmit bit for the current position |
| cfg_slot | input | 5 | Slot code: 1..24 payload, 31 framing bit, others off |
| cfg_mask | input | 8 | Bit positions to replace |
| cfg_parity | input | 2 | Frame filter: 0 all, 1 odd, 2 even, 3 all |
| cfg_enable | input | 1 | Insertion enable |
| cfg_pin_sel | input | 1 | Clock/data pin pair assigned to this block |
| ext_data | input | 1 | External NRZ insertion data |
| ext_clk | output | 1 | Gated strobe, high one cycle per requested bit |
| tx_out | output | 1 | Transmit stream after insertion |

## Verification
The assertions assume that the position inputs advance legally through a frame: `slot_num` 0 appears once per frame with `bit_num` 0, and then slots 1 to 24 follow with bit indices 0 to 7. The pass-through check also assumes that the block has run three cycles since reset before it compares delayed inputs. The stimulus walks a frame counter from 0 to 192 and derives slot and bit from it. It flips frame parity at each wrap, drives random `tx_in` and `ext_data` every cycle, and changes configuration both at frame starts and in the middle of frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SLOT_W = 5;
  localparam int BIT_W  = 3;
  localparam int MASK_W = 1 << BIT_W;

  typedef enum logic [1:0] {
    PAR_ALL  = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_BOTH = 2'd3
  } parity_e;

  typedef struct packed {
    logic              pin_sel;
    logic              enable;
    parity_e           parity;
    logic [MASK_W-1:0] mask;
    logic [SLOT_W-1:0] slot;
  } ins_cfg_t;

  function automatic logic parity_ok(parity_e p, logic odd);
    case (p)
      PAR_ODD:  return odd;
      PAR_EVEN: return !odd;
      default:  return 1'b1;
    endcase
  endfunction

  // Position match for one bit; last_slot and fbit_code come from the top.
  function automatic logic pos_hit(ins_cfg_t c, logic [SLOT_W-1:0] slot,
                                   logic [BIT_W-1:0] bitn, logic odd,
                                   logic [SLOT_W-1:0] last_slot,
                                   logic [SLOT_W-1:0] fbit_code);
    logic gate;
    gate = c.enable && c.pin_sel && parity_ok(c.parity, odd);
    if (!gate) return 1'b0;
    if (c.slot == fbit_code) return (slot == '0) && c.mask[0];
    if (c.slot == '0 || c.slot > last_slot) return 1'b0;
    return (slot == c.slot) && c.mask[bitn];
  endfunction
endpackage

// File: rtl/tsi_cfg_shadow.sv
module tsi_cfg_shadow
  import tsi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     boundary,
  input  ins_cfg_t cfg_in,
  output ins_cfg_t cfg_eff
);
  ins_cfg_t cfg_act;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_act <= '0;
    else if (boundary) cfg_act <= cfg_in;
  end

  // The framing-bit cycle already uses the incoming setting.
  assign cfg_eff = boundary ? cfg_in : cfg_act;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(cfg_act));
endmodule

// File: rtl/tsi_match.sv
module tsi_match
  import tsi_pkg::*;
#(
  parameter int N_SLOTS   = 24,
  parameter int FBIT_CODE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ins_cfg_t          cfg_eff,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [BIT_W-1:0]  bit_num,
  input  logic              frame_odd,
  output logic              hit_now
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS);
  localparam logic [SLOT_W-1:0] FBIT      = SLOT_W'(FBIT_CODE);

  assign hit_now = pos_hit(cfg_eff, slot_num, bit_num, frame_odd, LAST_SLOT, FBIT);

  // R7 R8
  hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |-> (cfg_eff.enable && cfg_eff.pin_sel));

  // R5 R6
  slot_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |-> ((slot_num == '0) ? (cfg_eff.slot == FBIT)
                                  : (cfg_eff.slot == slot_num)));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_now,
  input  logic tx_in,
  input  logic ext_data,
  output logic strobe,
  output logic tx_out
);
  logic hit_q, tx_q, out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      tx_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      hit_q <= hit_now;
      tx_q  <= tx_in;
      out_q <= hit_q ? ext_data : tx_q;
    end
  end

  assign strobe = hit_q;
  assign tx_out = out_q;

  // R10
  strobe_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (tx_out == $past(ext_data)));
endmodule

// File: rtl/tsi_inserter.sv
module tsi_inserter
  import tsi_pkg::*;
#(
  parameter int N_SLOTS   = 24,
  parameter int FBIT_CODE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [BIT_W-1:0]  bit_num,
  input  logic              frame_odd,
  input  logic              tx_in,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_enable,
  input  logic              cfg_pin_sel,
  input  logic              ext_data,
  output logic              ext_clk,
  output logic              tx_out
);
  ins_cfg_t cfg_in, cfg_eff;
  logic     frame_start;
  logic     hit_now;
  logic [1:0] warm;

  assign frame_start = (slot_num == '0);
  assign cfg_in = '{pin_sel: cfg_pin_sel, enable: cfg_enable,
                    parity: parity_e'(cfg_parity), mask: cfg_mask, slot: cfg_slot};

  tsi_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .boundary(frame_start),
    .cfg_in(cfg_in), .cfg_eff(cfg_eff));

  tsi_match #(.N_SLOTS(N_SLOTS), .FBIT_CODE(FBIT_CODE)) u_match (
    .clk(clk), .rst_n(rst_n), .cfg_eff(cfg_eff), .slot_num(slot_num),
    .bit_num(bit_num), .frame_odd(frame_odd), .hit_now(hit_now));

  tsi_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .hit_now(hit_now), .tx_in(tx_in),
    .ext_data(ext_data), .strobe(ext_clk), .tx_out(tx_out));

  // Cycles since reset, saturating; gates checks that look two cycles back.
  always_ff @(posedge clk) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  // R3 R11
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && !ext_clk) |=> (tx_out == $past(tx_in, 2)));

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk && slot_num == '0) |-> $past(slot_num) != '0);
endmodule

// File: tb/tsi_inserter_tb.sv
`timescale 1ns/1ps
module tsi_inserter_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] slot_num;
  logic [2:0] bit_num;
  logic frame_odd, tx_in;
  logic [4:0] cfg_slot;
  logic [7:0] cfg_mask;
  logic [1:0] cfg_parity;
  logic cfg_enable, cfg_pin_sel, ext_data;
  logic ext_clk, tx_out;

  always #2.5 clk = ~clk;

  tsi_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .slot_num(slot_num), .bit_num(bit_num),
    .frame_odd(frame_odd), .tx_in(tx_in), .cfg_slot(cfg_slot),
    .cfg_mask(cfg_mask), .cfg_parity(cfg_parity), .cfg_enable(cfg_enable),
    .cfg_pin_sel(cfg_pin_sel), .ext_data(ext_data), .ext_clk(ext_clk),
    .tx_out(tx_out));

  int vectors = 0, misses = 0;
  int idx = 0;
  bit odd = 1'b0;
  string tag = "R1";
  int strobes = 0;

  // Reference model state
  int m_code = 0, m_mask = 0, m_par = 0;
  bit m_en = 0, m_pin = 0;
  bit m_hit_q = 0, m_tx_q = 0, exp_tx = 0;

  function automatic bit ref_hit(int code, int mask, int par, bit en, bit pin,
                                 int pos, bit fodd);
    if (!en || !pin) return 0;
    if (par == 1 && !fodd) return 0;
    if (par == 2 && fodd) return 0;
    if (code == 31) return (pos == 0) && mask[0];
    if (code < 1 || code > 24 || pos == 0) return 0;
    return ((pos - 1) / 8 + 1 == code) && mask[(pos - 1) % 8];
  endfunction

  task automatic compare();
    vectors++;
    if (ext_clk !== m_hit_q) begin
      misses++;
      $display("FAIL %s/R10 ext_clk got %0b exp %0b at pos %0d", tag, ext_clk, m_hit_q, idx);
    end
    vectors++;
    if (tx_out !== exp_tx) begin
      misses++;
      $display("FAIL %s/R3/R11 tx_out got %0b exp %0b at pos %0d", tag, tx_out, exp_tx, idx);
    end
    if (ext_clk) strobes++;
  endtask

  task automatic step();
    bit nxt;
    @(negedge clk);
    compare();
    ext_data = 1'($urandom);
    tx_in    = 1'($urandom);
    slot_num = (idx == 0) ? 5'd0 : 5'((idx - 1) / 8 + 1);
    bit_num  = (idx == 0) ? 3'd0 : 3'((idx - 1) % 8);
    frame_odd = odd;
    // model the coming edge
    nxt = m_hit_q ? ext_data : m_tx_q;
    m_tx_q = tx_in;
    if (idx == 0) begin  // R9: settings taken at framing bit only
      m_code = cfg_slot; m_mask = cfg_mask; m_par = cfg_parity;
      m_en = cfg_enable; m_pin = cfg_pin_sel;
    end
    m_hit_q = ref_hit(m_code, m_mask, m_par, m_en, m_pin, idx, odd);
    exp_tx = nxt;
    idx++;
    if (idx == 193) begin idx = 0; odd = ~odd; end
  endtask

  task automatic run_bits(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_cfg(int code, int mask, int par, bit en, bit pin);
    cfg_slot = 5'(code); cfg_mask = 8'(mask); cfg_parity = 2'(par);
    cfg_enable = en; cfg_pin_sel = pin;
  endtask

  task automatic frames_with(string t, int code, int mask, int par, bit en, bit pin,
                             int nf, int exp_strobes);
    tag = t;
    set_cfg(code, mask, par, en, pin);
    run_bits(193 - idx);  // finish current frame under old setting
    strobes = 0;
    run_bits(193 * nf);
    if (exp_strobes >= 0) begin
      vectors++;
      if (strobes != exp_strobes) begin
        misses++;
        $display("FAIL %s strobe count got %0d exp %0d", t, strobes, exp_strobes);
      end
    end
  endtask

  initial begin
    rst_n = 0; slot_num = 0; bit_num = 0; frame_odd = 0; tx_in = 0; ext_data = 0;
    set_cfg(9, 8'hC3, 0, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (ext_clk !== 1'b0 || tx_out !== 1'b0) begin
      misses++;
      $display("FAIL R1 ext_clk/tx_out got %0b%0b exp 00", ext_clk, tx_out);
    end
    rst_n = 1;
    tag = "R1";
    run_bits(193);  // config before first frame start is picked up at idx 0
    // R2: slot 9, bits 0,1,6,7
    frames_with("R2", 9, 8'hC3, 0, 1, 1, 2, 8);
    frames_with("R2", 1, 8'h5A, 0, 1, 1, 2, 8);
    frames_with("R2", 24, 8'hFF, 3, 1, 1, 2, 16);
    // R4: parity filtering
    frames_with("R4", 24, 8'hFF, 1, 1, 1, 2, 8);
    frames_with("R4", 5, 8'h81, 2, 1, 1, 4, 4);
    // R5: framing bit
    frames_with("R5", 31, 8'h01, 0, 1, 1, 3, 3);
    frames_with("R5", 31, 8'hFE, 0, 1, 1, 2, 0);
    // R6: disabled codes
    frames_with("R6", 0, 8'hFF, 0, 1, 1, 2, 0);
    frames_with("R6", 27, 8'hFF, 0, 1, 1, 2, 0);
    frames_with("R6", 25, 8'hFF, 0, 1, 1, 1, 0);
    // R7 / R8
    frames_with("R7", 12, 8'hFF, 0, 0, 1, 2, 0);
    frames_with("R8", 12, 8'hFF, 0, 1, 0, 2, 0);
    // R9: mid-frame changes take effect next frame only
    frames_with("R9", 3, 8'h0F, 0, 1, 1, 0, -1);
    tag = "R9";
    run_bits(10);           // inside frame, slot 2
    set_cfg(2, 8'hFF, 0, 1, 1);
    run_bits(183);          // rest of frame still uses slot 3 mask 0F
    run_bits(100);
    set_cfg(0, 0, 0, 0, 0);
    run_bits(93 + 193);
    // R10 / R11: full-slot grabs with random external data, covered by the model
    frames_with("R10", 13, 8'hFF, 0, 1, 1, 2, 16);
    frames_with("R11", 20, 8'h00, 0, 1, 1, 2, 0);
    run_bits(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1000000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule